// File: doc/BRIEF.md
# Mask-Based Weighted Queue Scheduler

This block decides which output queue of a single port may send next. Each queue holds a 4-bit priority code, written through a small configuration port. A code of 9 marks the queue as strict. The strict queues form a group that starts at queue 0, and they are always served ahead of the other queues. Codes 0 to 8 are weights, and each weight turns into an 8-bit round-enable mask. The weighted queues share the port through a cycle of eight rounds. A queue may win in round n only when bit n of its mask is set.

The block receives one request flag per queue, meaning the queue is non-empty, together with the index of the port's last queue. It presents a grant as an index, as a one-hot vector and as a strict/weighted indication. The consumer accepts the grant with `grant_accept` in the same cycle. Walk state moves forward only on an accepted weighted grant.

Two flags report problems in the stored configuration. One reports a strict queue placed outside the leading group. The other reports a code above 9.

Top module: `mask_wrr_sched`

## Requirements
- R1: A weighted code maps to a round mask: 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7F, 8→0xFF. Bit n of the mask enables round n. A weighted queue is granted only in a round whose bit is set in its mask.
- R2: A queue with code 0 is never granted. If the only requesting queues have code 0, `grant_valid` stays low.
- R3: A queue with code 9 is strict only while every lower-index queue also holds code 9. Among the requesting strict queues, the lowest index is granted, with `grant_strict` high. This happens before any weighted queue is considered.
- R4: `cfg_order_err` is high when some active queue holds code 9 while the queue just below it does not. Such a queue is scheduled as a weighted queue with mask 0xFF.
- R5: `cfg_code_err` is high when any active queue holds a code from 10 to 15. Such a queue is scheduled as a weighted queue with mask 0xFF.
- R6: Weighted queues are searched in increasing index order, starting one past the last accepted weighted grant. Accepting a grant of the tail queue restarts the walk at queue 0 and advances the 3-bit round by one, modulo 8.
- R7: When no weighted queue is eligible in the current round, the search moves on to later rounds in the same cycle. A grant is presented whenever a strict queue requests, or a weighted queue with a nonzero mask requests.
- R8: Walk state changes only on a cycle with `grant_valid`, `grant_accept` and a weighted grant. Without accept, the same grant is offered again.
- R9: A write sets a queue's code from the following cycle onward. It leaves the round and the walk position unchanged.
- R10: Queues with index above `tail_idx` are ignored. They are never granted and never raise error flags.
- R11: After reset, every code is 8, the round is 0 and the walk starts at queue 0. Both error flags are low, and no grant is presented without requests.
- R12: `grant_onehot` has exactly bit `grant_idx` set while `grant_valid` is high, and is zero otherwise. Every grant names a requesting queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one queue's priority code |
| cfg_idx | input | IW | Queue written |
| cfg_code | input | 4 | Priority code written (0-8 weight, 9 strict) |
| tail_idx | input | IW | Index of the port's last queue |
| req | input | NQ | Per-queue non-empty flags |
| grant_accept | input | 1 | Consumer takes the presented grant |
| grant_valid | output | 1 | A grant is presented |
| grant_idx | output | IW | Index of the granted queue |
| grant_onehot | output | NQ | One-hot form of the grant |
| grant_strict | output | 1 | The grant comes from the strict group |
| cfg_order_err | output | 1 | Strict queue outside the leading group |
| cfg_code_err | output | 1 | Out-of-range code on an active queue |

## Verification
The situations that are hard to reach are two. In the first, the walk pointer sits mid-port while the current round has no eligible queue, so the search must jump several rounds and wrap back to queues below the pointer. In the second, the tail shrinks below the pointer. Sparse masks (weights 1 and 3) combined with a single requesting queue drive the search through round skips. A long stretch of random requests, withheld accepts, live code writes and tail changes then drives the pointer and the round into these combinations. Each result is compared against a step-by-step walk model kept in the bench.

// File: rtl/mwq_pkg.sv
package mwq_pkg;
  localparam int CODE_W = 4;
  localparam int ROUNDS = 8;
  localparam int RND_W  = 3;
  localparam logic [CODE_W-1:0] CODE_STRICT = 4'd9;
  localparam logic [CODE_W-1:0] CODE_RESET  = 4'd8;

  typedef logic [ROUNDS-1:0] rmask_t;

  // weight to evenly spread round-enable mask; strict and bad codes run every round
  function automatic rmask_t code_to_mask(input logic [CODE_W-1:0] c);
    rmask_t m;
    case (c)
      4'd0:    m = 8'h00;
      4'd1:    m = 8'h01;
      4'd2:    m = 8'h11;
      4'd3:    m = 8'h49;
      4'd4:    m = 8'h55;
      4'd5:    m = 8'h57;
      4'd6:    m = 8'h77;
      4'd7:    m = 8'h7F;
      default: m = 8'hFF;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/mwq_cfg_store.sv
module mwq_cfg_store
  import mwq_pkg::*;
#(
  parameter int NQ = 32,
  parameter int IW = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [IW-1:0]              cfg_idx,
  input  logic [CODE_W-1:0]          cfg_code,
  input  logic [IW-1:0]              tail_idx,
  output logic [NQ-1:0]              active_o,
  output logic [NQ-1:0]              strict_o,
  output logic [NQ-1:0][ROUNDS-1:0]  mask_o,
  output logic                       order_err_o,
  output logic                       code_err_o
);
  logic [NQ-1:0][CODE_W-1:0] code_q, code_d;
  logic [NQ-1:0]             misplaced, bad_code;

  always_comb begin
    code_d = code_q;
    if (cfg_we && (int'(cfg_idx) < NQ)) code_d[cfg_idx] = cfg_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) code_q[i] <= CODE_RESET;
    end else if (cfg_we) begin
      code_q <= code_d;
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic is_nine;
    assign is_nine     = (code_q[g] == CODE_STRICT);
    assign active_o[g] = (int'(tail_idx) >= g);
    if (g == 0) begin : g_head
      assign strict_o[g] = is_nine && active_o[g];
    end else begin : g_body
      assign strict_o[g] = is_nine && active_o[g] && strict_o[g-1];
    end
    assign mask_o[g]    = code_to_mask(code_q[g]);
    assign misplaced[g] = is_nine && active_o[g] && !strict_o[g];
    assign bad_code[g]  = active_o[g] && (code_q[g] > CODE_STRICT);
  end

  assign order_err_o = |misplaced;
  assign code_err_o  = |bad_code;

  // R9: a write is visible in the stored code on the next cycle
  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (int'(cfg_idx) < NQ)) |=> (code_q[$past(cfg_idx)] == $past(cfg_code)));
endmodule

// File: rtl/mwq_strict_pick.sv
module mwq_strict_pick #(
  parameter int NQ = 32,
  parameter int IW = 5
) (
  input  logic [NQ-1:0] sreq,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (sreq[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mwq_weighted_pick.sv
module mwq_weighted_pick
  import mwq_pkg::*;
#(
  parameter int NQ = 32,
  parameter int IW = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NQ-1:0]             wreq,
  input  logic [NQ-1:0][ROUNDS-1:0] mask,
  input  logic [IW-1:0]             tail_idx,
  input  logic                      take,
  output logic                      hit_o,
  output logic [IW-1:0]             idx_o
);
  logic [RND_W-1:0] round_q, round_d, sel_round, rr;
  logic [IW-1:0]    ptr_q, ptr_d;
  logic             in_win;

  // Offsets scanned high to low, indices high to low: the last hit written
  // is the nearest round, then the lowest index in it.
  always_comb begin
    hit_o     = 1'b0;
    idx_o     = '0;
    sel_round = round_q;
    rr        = round_q;
    in_win    = 1'b0;
    for (int k = ROUNDS; k >= 0; k--) begin
      rr = round_q + RND_W'(k);
      for (int i = NQ - 1; i >= 0; i--) begin
        if (k == 0)           in_win = (i >= int'(ptr_q));
        else if (k == ROUNDS) in_win = (i < int'(ptr_q));
        else                  in_win = 1'b1;
        if (wreq[i] && mask[i][rr] && in_win) begin
          hit_o     = 1'b1;
          idx_o     = IW'(i);
          sel_round = rr;
        end
      end
    end
  end

  always_comb begin
    round_d = round_q;
    ptr_d   = ptr_q;
    if (take) begin
      if (idx_o == tail_idx) begin
        ptr_d   = '0;
        round_d = sel_round + RND_W'(1);
      end else begin
        ptr_d   = idx_o + IW'(1);
        round_d = sel_round;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      round_q <= '0;
      ptr_q   <= '0;
    end else if (take) begin
      round_q <= round_d;
      ptr_q   <= ptr_d;
    end
  end

  // R8: walk state only moves on an accepted weighted grant
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(round_q) && $stable(ptr_q)));

  // R6: accepting the tail restarts the walk at queue 0
  p_tail_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && idx_o == tail_idx) |=> (ptr_q == '0));
endmodule

// File: rtl/mask_wrr_sched.sv
module mask_wrr_sched
  import mwq_pkg::*;
#(
  parameter int NQ = 32,
  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_idx,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic [IW-1:0]     tail_idx,
  input  logic [NQ-1:0]     req,
  input  logic              grant_accept,
  output logic              grant_valid,
  output logic [IW-1:0]     grant_idx,
  output logic [NQ-1:0]     grant_onehot,
  output logic              grant_strict,
  output logic              cfg_order_err,
  output logic              cfg_code_err
);
  logic [NQ-1:0]             active, strict, wreq, sreq, live_mask;
  logic [NQ-1:0][ROUNDS-1:0] mask;
  logic                      s_hit, w_hit, take_w;
  logic [IW-1:0]             s_idx, w_idx;

  mwq_cfg_store #(.NQ(NQ), .IW(IW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_code(cfg_code), .tail_idx(tail_idx), .active_o(active),
    .strict_o(strict), .mask_o(mask), .order_err_o(cfg_order_err),
    .code_err_o(cfg_code_err)
  );

  assign sreq = req & strict;
  assign wreq = req & active & ~strict;

  for (genvar g = 0; g < NQ; g++) begin : g_live
    assign live_mask[g] = |mask[g];
  end

  mwq_strict_pick #(.NQ(NQ), .IW(IW)) u_strict (
    .sreq(sreq), .hit_o(s_hit), .idx_o(s_idx)
  );

  assign take_w = grant_accept && w_hit && !s_hit;

  mwq_weighted_pick #(.NQ(NQ), .IW(IW)) u_wpick (
    .clk(clk), .rst_n(rst_n), .wreq(wreq), .mask(mask),
    .tail_idx(tail_idx), .take(take_w), .hit_o(w_hit), .idx_o(w_idx)
  );

  always_comb begin
    grant_valid  = s_hit || w_hit;
    grant_strict = s_hit;
    grant_idx    = s_hit ? s_idx : w_idx;
    grant_onehot = '0;
    if (grant_valid) grant_onehot[grant_idx] = 1'b1;
  end

  // R12: at most one queue granted, named by the index
  p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_onehot) && (grant_valid == (|grant_onehot)));
  // R12: every grant names a requesting queue
  p_grant_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> req[grant_idx]);
  // R3: a requesting strict queue always beats weighted queues
  p_strict_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|sreq) |-> (grant_valid && grant_strict));
  // R10: nothing above the tail is granted
  p_above_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (grant_idx <= tail_idx));
  // R2: a weighted grant never goes to an all-zero mask
  p_zero_weight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_strict) |-> live_mask[grant_idx]);
  // R7: no idle cycle while an eligible weighted queue requests
  p_no_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(wreq & live_mask)) |-> grant_valid);
endmodule

// File: tb/sim_mask_wrr_sched.sv
module sim_mask_wrr_sched;
  localparam int PERIOD = 10;
  localparam int NQ = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [3:0]    cfg_code = '0;
  logic [IW-1:0] tail_idx = '0;
  logic [NQ-1:0] req = '0;
  logic          grant_accept = 1'b0;
  logic          grant_valid, grant_strict, cfg_order_err, cfg_code_err;
  logic [IW-1:0] grant_idx;
  logic [NQ-1:0] grant_onehot;

  always #(PERIOD/2) clk = ~clk;

  mask_wrr_sched #(.NQ(NQ)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_code(cfg_code), .tail_idx(tail_idx), .req(req),
    .grant_accept(grant_accept), .grant_valid(grant_valid),
    .grant_idx(grant_idx), .grant_onehot(grant_onehot),
    .grant_strict(grant_strict), .cfg_order_err(cfg_order_err),
    .cfg_code_err(cfg_code_err)
  );

  typedef struct {
    bit    v;
    int    idx;
    bit    st;
    string tag;
  } exp_t;

  exp_t q_exp[$];
  event mon_ev;
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;

  int mprio[NQ];
  int mround, mptr, mtail, pend_tail;

  function automatic int mask_of(int c);
    case (c)
      0: return 'h00; 1: return 'h01; 2: return 'h11; 3: return 'h49;
      4: return 'h55; 5: return 'h57; 6: return 'h77; 7: return 'h7F;
      default: return 'hFF;
    endcase
  endfunction

  task automatic model(input logic [NQ-1:0] rq, output bit v, output int idx,
                       output bit st, output int nr, output int np);
    bit sp[NQ];
    bit run = 1;
    int pos, r;
    v = 0; idx = 0; st = 0; nr = mround; np = mptr;
    for (int i = 0; i < NQ; i++) begin
      run = run && (i <= mtail) && (mprio[i] == 9);
      sp[i] = run;
    end
    for (int i = 0; i < NQ; i++)
      if (!v && sp[i] && rq[i]) begin v = 1; st = 1; idx = i; end
    if (v) return;
    pos = mptr; r = mround;
    for (int s = 0; s < 100; s++) begin
      if (pos > mtail) begin pos = 0; r = (r + 1) % 8; end
      if (rq[pos] && !sp[pos] && mask_of(mprio[pos])[r]) begin
        v = 1; idx = pos;
        nr = (pos == mtail) ? (r + 1) % 8 : r;
        np = (pos == mtail) ? 0 : pos + 1;
        return;
      end
      pos++;
    end
  endtask

  task automatic step(input logic [NQ-1:0] rq, input bit acc, input string tag,
                      input bit cw = 0, input int ci = 0, input int cc = 0);
    exp_t e;
    int nr, np;
    @(negedge clk);
    mtail = pend_tail;
    tail_idx = IW'(mtail);
    req = rq; grant_accept = acc;
    cfg_we = cw; cfg_idx = IW'(ci); cfg_code = 4'(cc);
    model(rq, e.v, e.idx, e.st, nr, np);
    e.tag = tag;
    q_exp.push_back(e);
    #(PERIOD/4);
    -> mon_ev;
    if (e.v && acc && !e.st) begin mround = nr; mptr = np; end
    if (cw) mprio[ci] = cc;
  endtask

  task automatic fail_line(input string tag, input string what, input int act, input int exp);
    failures++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  initial forever begin
    exp_t e;
    @(mon_ev);
    #0;
    e = q_exp.pop_front();
    checks++;
    if (grant_valid !== e.v) fail_line(e.tag, "grant_valid", int'(grant_valid), int'(e.v));
    else if (e.v) begin
      checks++;
      if (int'(grant_idx) != e.idx) fail_line(e.tag, "grant_idx", int'(grant_idx), e.idx);
      if (grant_strict !== e.st) fail_line(e.tag, "grant_strict", int'(grant_strict), int'(e.st));
      if (grant_onehot !== (NQ'(1) << e.idx)) fail_line(e.tag, "grant_onehot", int'(grant_onehot), 1 << e.idx);
    end else if (grant_onehot !== '0) fail_line(e.tag, "grant_onehot", int'(grant_onehot), 0);
  end

  task automatic chk_err(input string tag);
    bit oe = 0, ce = 0;
    step('0, 0, tag);
    for (int i = 0; i <= mtail; i++) begin
      if (mprio[i] > 9) ce = 1;
      if (i > 0 && mprio[i] == 9 && mprio[i-1] != 9) oe = 1;
      if (i == 0 && mprio[i] == 9) oe = oe;
    end
    checks++;
    if (cfg_order_err !== oe) fail_line(tag, "cfg_order_err", int'(cfg_order_err), int'(oe));
    checks++;
    if (cfg_code_err !== ce) fail_line(tag, "cfg_code_err", int'(cfg_code_err), int'(ce));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NQ; i++) mprio[i] = 8;
    mround = 0; mptr = 0; mtail = 3; pend_tail = 3;
    tail_idx = 3'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    step('0, 1, "R11");
    chk_err("R11");
    // R6: equal weights walk in index order and wrap
    for (int n = 0; n < 9; n++) step(8'h0F, 1, "R6");
    // R8: without accept the same grant repeats
    for (int n = 0; n < 3; n++) step(8'h06, 0, "R8");
    step(8'h06, 1, "R8");
    // R1: mixed weights 8, 1, 3
    step('0, 1, "R1", 1, 1, 1);
    step('0, 1, "R1", 1, 2, 3);
    for (int n = 0; n < 30; n++) step(8'h07, 1, "R1");
    // R2: weight 0 only
    step('0, 1, "R2", 1, 3, 0);
    for (int n = 0; n < 3; n++) step(8'h08, 1, "R2");
    // R7: a sparse mask forces round skipping every grant
    for (int n = 0; n < 5; n++) step(8'h02, 1, "R7");
    for (int n = 0; n < 5; n++) step(8'h04, 1, "R7");
    // R10: requests above the tail are ignored
    for (int n = 0; n < 2; n++) step(8'h30, 1, "R10");
    pend_tail = 5;
    for (int n = 0; n < 3; n++) step(8'h30, 1, "R10");
    pend_tail = 3;
    // R3: leading strict group
    step('0, 1, "R3", 1, 0, 9);
    step('0, 1, "R3", 1, 1, 9);
    for (int n = 0; n < 3; n++) step(8'h0E, 1, "R3");
    step(8'h0F, 1, "R3");
    chk_err("R3");
    // R4: strict code after a weighted queue
    step('0, 1, "R4", 1, 3, 9);
    chk_err("R4");
    for (int n = 0; n < 3; n++) step(8'h0C, 1, "R4");
    // R5: out-of-range code acts as full mask
    step('0, 1, "R5", 1, 2, 12);
    chk_err("R5");
    for (int n = 0; n < 4; n++) step(8'h04, 1, "R5");
    // R9: writes during traffic keep the walk state
    step('0, 1, "R9", 1, 0, 8);
    step('0, 1, "R9", 1, 1, 2);
    step('0, 1, "R9", 1, 2, 4);
    step('0, 1, "R9", 1, 3, 1);
    for (int n = 0; n < 12; n++) step(8'h0F, 1, "R9", (n % 4) == 1, n % 4, 5 + (n % 3));
    chk_err("R9");
    // R12: random mix
    for (int n = 0; n < 600; n++) begin
      bit cw;
      if (($urandom % 40) == 0) pend_tail = $urandom % NQ;
      cw = (($urandom % 6) == 0);
      step(NQ'($urandom), ($urandom % 4) != 0, "R12", cw, $urandom % NQ, $urandom % 11);
      if ((n % 50) == 49) chk_err("R12");
    end
    @(negedge clk);
    #(PERIOD/2);
    finish_run();
  end
endmodule